// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset

This block is a watchdog that counts slow-clock enable ticks and expects software to restart it before a selectable period runs out. When the period runs out it raises a timeout interrupt flag and a separate wakeup flag. If reset generation is enabled, it then opens a grace window of 1026 ticks. A restart inside that window cancels the reset. If no restart arrives, the block emits a one-cycle system reset pulse and latches a sticky reset-cause flag.

The clock source and any divider sit outside the block, which sees only a single-cycle `tick` enable. The control fields (run enable, interrupt enable, reset enable, period select) live in a write-protected register. A write changes it only while `unlock` is high. The status flags are cleared by write-1-to-clear pulses.

The behaviour is built around a four-state machine:
- IDLE: the watchdog is stopped.
- COUNT: the counter advances on each tick.
- GRACE: the 1026-tick window after a timeout.
- FIRE: the single cycle in which the reset pulse is driven.

Named transitions:
- start (IDLE to COUNT, counter cleared).
- stop (any state to IDLE, when the run enable is low).
- restart (COUNT or GRACE to COUNT, counter cleared).
- expire-wrap (COUNT to COUNT, counter cleared, when reset generation is off).
- expire-arm (COUNT to GRACE).
- bite (GRACE to FIRE).
- resume (FIRE to COUNT, counter cleared).

Top module: `wdog_guard`

## Requirements
- R1: With period select `s` (control bits [5:3]), a timeout occurs after 2^(4+2·s) counted ticks from start or restart. It sets both `int_flag` and `wake_flag`. With one tick per cycle, the flags first read high 2^(4+2·s)+1 cycles after the cycle whose write enabled the block.
- R2: The counter and the grace counter advance only in cycles where `tick` is high. With `tick` low, no timeout ever occurs.
- R3: With reset enable (control bit 2) set, `sys_rst` is high for exactly one cycle, 1026 ticks after the timeout, unless a restart arrives first.
- R4: A `kick` while running clears the count, abandons any grace window and starts a full new period. It leaves the status flags unchanged.
- R5: With reset enable clear, a timeout never produces `sys_rst`. The counter restarts from zero, so a further timeout follows one period later.
- R6: `irq` is high exactly when `int_flag` is set and interrupt enable (control bit 1) is set.
- R7: `clr_int` and `clr_wake` each clear only their own flag. A new timeout in the same cycle as a clear wins, and the flag stays set.
- R8: `rst_cause` rises together with the `sys_rst` pulse. It stays set until `clr_cause`, and other clears do not affect it.
- R9: A control write with `unlock` low leaves `ctl_rdata` and the running behaviour unchanged.
- R10: Clearing run enable (control bit 0) stops the watchdog: no flag or reset follows. Setting it again restarts counting from zero.
- R11: After `rst_n`, all flags, `irq`, `sys_rst` and the control register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Counter clock enable from the external slow-clock source |
| unlock | input | 1 | Protection unlock; control writes take effect only while high |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data: [0] run, [1] int enable, [2] reset enable, [5:3] period select |
| kick | input | 1 | Restart command |
| clr_int | input | 1 | Write-1-to-clear for the timeout interrupt flag |
| clr_wake | input | 1 | Write-1-to-clear for the wakeup flag |
| clr_cause | input | 1 | Write-1-to-clear for the reset-cause flag |
| ctl_rdata | output | 6 | Current control register contents |
| int_flag | output | 1 | Timeout interrupt status |
| wake_flag | output | 1 | Timeout wakeup status |
| irq | output | 1 | Interrupt request (flag gated by interrupt enable) |
| sys_rst | output | 1 | One-cycle system reset pulse |
| rst_cause | output | 1 | Sticky flag: the watchdog issued a reset |

## Verification
The hardest situation to reach is a restart landing deep inside the grace window. The window is only visible through the absence of a reset. Its exact length is seen only when a later pulse arrives on time. The stimulus runs the shortest period, waits for the timeout flag, and sends `kick` 500 ticks into the window. It then confirms that no pulse appears for 1041 cycles and that one appears in the next cycle. The second hard case is a clear arriving in the same cycle as a fresh timeout. The bench reaches it by counting a second period exactly and raising `clr_int` in the cycle of the expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned SEL_W = 3;
    localparam int unsigned CFG_W = SEL_W + 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_GRACE = 2'd2,
        ST_FIRE  = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             rst_en;
        logic             int_en;
        logic             run;
    } wd_cfg_t;

endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unlock,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output wd_cfg_t          cfg
);

    logic wr_ok;

    assign wr_ok = we && unlock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_ok) begin
            cfg <= wd_cfg_t'(wdata);
        end
    end

    // R9: a locked write must not alter the register
    assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !unlock) |=> $stable(cfg));

endmodule

// File: rtl/wdog_period_dec.sv
module wdog_period_dec #(
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned BASE_EXP = 4,
    parameter int unsigned EXP_STEP = 2,
    parameter int unsigned CNT_W    = 18
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] cnt,
    output logic             at_term
);

    localparam int unsigned NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] term_tab [NSEL];

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_term
            localparam int unsigned EXP_G = BASE_EXP + EXP_STEP * g;
            assign term_tab[g] = CNT_W'((64'd1 << EXP_G) - 64'd1);
        end
    endgenerate

    assign at_term = (cnt >= term_tab[sel]);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W       = 18,
    parameter int unsigned GRACE_TICKS = 1026
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             rst_en,
    input  logic             kick,
    input  logic             at_term,
    output logic [CNT_W-1:0] cnt,
    output logic             tmo_evt,
    output logic             bite_evt,
    output logic             sys_rst
);

    localparam int unsigned GR_W = $clog2(GRACE_TICKS);
    localparam logic [GR_W-1:0] GR_LAST = GR_W'(GRACE_TICKS - 1);

    wd_state_e       state_q, state_d;
    logic [GR_W-1:0] gcnt_q;
    logic            cnt_clr;
    logic            g_last;

    assign g_last = (gcnt_q == GR_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and events
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        tmo_evt  = 1'b0;
        bite_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    state_d = ST_COUNT;           // start
                    cnt_clr = 1'b1;
                end
            end
            ST_COUNT: begin
                if (!run) begin
                    state_d = ST_IDLE;            // stop
                end else if (kick) begin
                    cnt_clr = 1'b1;               // restart
                end else if (tick && at_term) begin
                    tmo_evt = 1'b1;
                    cnt_clr = 1'b1;
                    state_d = rst_en ? ST_GRACE : ST_COUNT; // expire-arm / expire-wrap
                end
            end
            ST_GRACE: begin
                if (!run) begin
                    state_d = ST_IDLE;            // stop
                end else if (kick) begin
                    state_d = ST_COUNT;           // restart
                    cnt_clr = 1'b1;
                end else if (tick && g_last) begin
                    state_d  = ST_FIRE;           // bite
                    bite_evt = 1'b1;
                end
            end
            ST_FIRE: begin
                if (!run) begin
                    state_d = ST_IDLE;            // stop
                end else begin
                    state_d = ST_COUNT;           // resume
                    cnt_clr = 1'b1;
                end
            end
        endcase
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            gcnt_q <= '0;
        end else begin
            if (cnt_clr) begin
                cnt <= '0;
            end else if (state_q == ST_COUNT && tick) begin
                cnt <= cnt + 1'b1;
            end
            if (state_q != ST_GRACE) begin
                gcnt_q <= '0;
            end else if (tick && !g_last) begin
                gcnt_q <= gcnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sys_rst = (state_q == ST_FIRE);
    end

    // R3: the reset pulse lasts one cycle
    assert_rst_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    // R3: the reset is only reached through the grace window
    assert_rst_after_grace_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> ($past(state_q) == ST_GRACE));

    // R4: a restart while running clears the count and returns to counting
    assert_kick_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kick) |=> (state_q == ST_COUNT && cnt == '0));

    // R10: clearing run stops the machine
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state_q == ST_IDLE && !sys_rst));

    // R5: without reset enable the grace window is never entered
    assert_no_grace_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_evt && !rst_en) |=> (state_q != ST_GRACE));

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo_evt,
    input  logic bite_evt,
    input  logic clr_int,
    input  logic clr_wake,
    input  logic clr_cause,
    output logic int_flag,
    output logic wake_flag,
    output logic rst_cause
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_flag  <= 1'b0;
            wake_flag <= 1'b0;
            rst_cause <= 1'b0;
        end else begin
            if (tmo_evt)        int_flag  <= 1'b1;
            else if (clr_int)   int_flag  <= 1'b0;
            if (tmo_evt)        wake_flag <= 1'b1;
            else if (clr_wake)  wake_flag <= 1'b0;
            if (bite_evt)       rst_cause <= 1'b1;
            else if (clr_cause) rst_cause <= 1'b0;
        end
    end

    // R7: flags hold unless their own clear arrives
    assert_int_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && !clr_int) |=> int_flag);

    assert_wake_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !clr_wake) |=> wake_flag);

    // R8: the reset cause holds until its own clear
    assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_cause && !clr_cause) |=> rst_cause);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_EXP    = 4,
    parameter int unsigned EXP_STEP    = 2,
    parameter int unsigned GRACE_TICKS = 1026
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             unlock,
    input  logic             ctl_we,
    input  logic [CFG_W-1:0] ctl_wdata,
    input  logic             kick,
    input  logic             clr_int,
    input  logic             clr_wake,
    input  logic             clr_cause,
    output logic [CFG_W-1:0] ctl_rdata,
    output logic             int_flag,
    output logic             wake_flag,
    output logic             irq,
    output logic             sys_rst,
    output logic             rst_cause
);

    localparam int unsigned CNT_W = BASE_EXP + EXP_STEP * ((1 << SEL_W) - 1);

    wd_cfg_t          cfg;
    logic [CNT_W-1:0] cnt;
    logic             at_term;
    logic             tmo_evt;
    logic             bite_evt;

    wdog_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .unlock(unlock),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .cfg   (cfg)
    );

    wdog_period_dec #(
        .SEL_W   (SEL_W),
        .BASE_EXP(BASE_EXP),
        .EXP_STEP(EXP_STEP),
        .CNT_W   (CNT_W)
    ) u_dec (
        .sel    (cfg.sel),
        .cnt    (cnt),
        .at_term(at_term)
    );

    wdog_fsm #(
        .CNT_W      (CNT_W),
        .GRACE_TICKS(GRACE_TICKS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (cfg.run),
        .rst_en  (cfg.rst_en),
        .kick    (kick),
        .at_term (at_term),
        .cnt     (cnt),
        .tmo_evt (tmo_evt),
        .bite_evt(bite_evt),
        .sys_rst (sys_rst)
    );

    wdog_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmo_evt  (tmo_evt),
        .bite_evt (bite_evt),
        .clr_int  (clr_int),
        .clr_wake (clr_wake),
        .clr_cause(clr_cause),
        .int_flag (int_flag),
        .wake_flag(wake_flag),
        .rst_cause(rst_cause)
    );

    assign ctl_rdata = CFG_W'(cfg);
    assign irq       = int_flag && cfg.int_en;

    // R8: the cause flag accompanies every reset pulse
    assert_cause_with_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> rst_cause);

    // R6: interrupt request only with the enable set
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_flag && cfg.int_en));

endmodule

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       unlock = 1'b0;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       kick = 1'b0;
    logic       clr_int = 1'b0;
    logic       clr_wake = 1'b0;
    logic       clr_cause = 1'b0;
    logic [5:0] ctl_rdata;
    logic       int_flag, wake_flag, irq, sys_rst, rst_cause;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    wdog_guard dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .unlock(unlock),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .kick(kick),
        .clr_int(clr_int), .clr_wake(clr_wake), .clr_cause(clr_cause),
        .ctl_rdata(ctl_rdata), .int_flag(int_flag), .wake_flag(wake_flag),
        .irq(irq), .sys_rst(sys_rst), .rst_cause(rst_cause)
    );

    always @(negedge clk) if (rst_n && sys_rst) pulses++;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input bit run, input bit ie, input bit re,
                          input logic [2:0] sel, input bit unl);
        ctl_wdata = {sel, re, ie, run};
        unlock    = unl;
        ctl_we    = 1'b1;
        step(1);
        ctl_we    = 1'b0;
        unlock    = 1'b0;
    endtask

    task automatic clr_all();
        wr_cfg(0, 0, 0, 3'd0, 1);
        clr_int = 1'b1; clr_wake = 1'b1; clr_cause = 1'b1;
        step(1);
        clr_int = 1'b0; clr_wake = 1'b0; clr_cause = 1'b0;
        step(2);
    endtask

    task automatic t_reset();
        check("R11 int_flag", int_flag, 0);
        check("R11 wake_flag", wake_flag, 0);
        check("R11 irq", irq, 0);
        check("R11 sys_rst", sys_rst, 0);
        check("R11 rst_cause", rst_cause, 0);
        check("R11 ctl_rdata", ctl_rdata, 0);
    endtask

    task automatic t_period(input logic [2:0] sel, input int per);
        wr_cfg(1, 1, 0, sel, 1);
        step(per);
        check("R1 flag before period", int_flag, 0);
        step(1);
        check("R1 int_flag at period", int_flag, 1);
        check("R1 wake_flag at period", wake_flag, 1);
        check("R6 irq with enable", irq, 1);
        clr_all();
    endtask

    task automatic t_wrap();
        int p0;
        p0 = pulses;
        wr_cfg(1, 1, 0, 3'd0, 1);
        step(17);
        check("R5 first timeout", int_flag, 1);
        clr_int = 1'b1; clr_wake = 1'b1;
        step(1);
        clr_int = 1'b0; clr_wake = 1'b0;
        step(14);
        check("R5 before second timeout", int_flag, 0);
        step(1);
        check("R5 second timeout", wake_flag, 1);
        step(1200);
        check("R5 no reset pulse", pulses - p0, 0);
        clr_all();
    endtask

    task automatic t_ticks();
        tick = 1'b0;
        wr_cfg(1, 1, 0, 3'd0, 1);
        step(200);
        check("R2 no timeout without tick", int_flag, 0);
        tick = 1'b1;
        step(15);
        check("R2 before 16 ticks", int_flag, 0);
        step(1);
        check("R2 after 16 ticks", int_flag, 1);
        clr_all();
    endtask

    task automatic t_grace();
        wr_cfg(1, 1, 1, 3'd0, 1);
        step(17);
        check("R3 timeout seen", int_flag, 1);
        step(1025);
        check("R3 no reset inside window", sys_rst, 0);
        step(1);
        check("R3 reset after 1026 ticks", sys_rst, 1);
        check("R8 cause with reset", rst_cause, 1);
        step(1);
        check("R3 reset one cycle", sys_rst, 0);
        clr_int = 1'b1; clr_wake = 1'b1;
        step(1);
        clr_int = 1'b0; clr_wake = 1'b0;
        check("R8 cause kept by other clears", rst_cause, 1);
        clr_cause = 1'b1;
        step(1);
        clr_cause = 1'b0;
        check("R8 cause cleared", rst_cause, 0);
        clr_all();
    endtask

    task automatic t_kick();
        int p0;
        wr_cfg(1, 0, 1, 3'd0, 1);
        step(17);
        check("R6 flag set", int_flag, 1);
        check("R6 irq masked", irq, 0);
        step(500);
        kick = 1'b1;
        step(1);
        kick = 1'b0;
        p0 = pulses;
        step(1041);
        check("R4 no reset after kick", pulses - p0, 0);
        check("R4 flags kept by kick", wake_flag, 1);
        step(1);
        check("R4 reset after fresh period and window", sys_rst, 1);
        clr_all();
    endtask

    task automatic t_clear();
        wr_cfg(1, 1, 0, 3'd0, 1);
        step(17);
        clr_int = 1'b1;
        step(1);
        clr_int = 1'b0;
        check("R7 clr_int clears int", int_flag, 0);
        check("R7 clr_int keeps wake", wake_flag, 1);
        clr_wake = 1'b1;
        step(1);
        clr_wake = 1'b0;
        check("R7 clr_wake clears wake", wake_flag, 0);
        step(13);
        clr_int = 1'b1;
        step(1);
        clr_int = 1'b0;
        check("R7 set wins over clear", int_flag, 1);
        clr_all();
    endtask

    task automatic t_protect();
        wr_cfg(1, 1, 1, 3'd2, 0);
        check("R9 locked write ignored", ctl_rdata, 0);
        step(100);
        check("R9 no run after locked write", int_flag, 0);
        wr_cfg(1, 1, 0, 3'd1, 1);
        check("R9 unlocked write", ctl_rdata, 6'b001011);
        wr_cfg(0, 0, 0, 3'd0, 0);
        check("R9 locked stop ignored", ctl_rdata, 6'b001011);
        step(63);
        check("R9 still counting before period", int_flag, 0);
        step(1);
        check("R9 still counting at period", int_flag, 1);
        clr_all();
    endtask

    task automatic t_disable();
        int p0;
        p0 = pulses;
        wr_cfg(1, 1, 1, 3'd0, 1);
        step(17);
        wr_cfg(0, 1, 1, 3'd0, 1);
        step(1);
        clr_int = 1'b1; clr_wake = 1'b1;
        step(1);
        clr_int = 1'b0; clr_wake = 1'b0;
        step(1500);
        check("R10 no reset when stopped", pulses - p0, 0);
        check("R10 no flag when stopped", int_flag, 0);
        wr_cfg(1, 1, 1, 3'd0, 1);
        step(16);
        check("R10 restart from zero before", int_flag, 0);
        step(1);
        check("R10 restart from zero at period", int_flag, 1);
        clr_all();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_period(3'd0, 16);
        t_period(3'd1, 64);
        t_period(3'd2, 256);
        t_wrap();
        t_ticks();
        t_grace();
        t_kick();
        t_clear();
        t_protect();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule